// File: doc/BRIEF.md
# Carrier-Compare PWM Channel

This block drives a single pulse-width-modulated output bit. A counting clock is derived from the system clock by a power-of-two divider. On each counting tick a carrier counter advances. The carrier is either a sawtooth (rises, then wraps to zero) or a symmetrical triangle (rises to half the period, then falls back). A compare value is tested against the carrier every clock. The output bit is set while the compare value exceeds the carrier, and a polarity input can invert it.

The compare value is held in an active register. Depending on the selected load mode, that register takes a new value at once, at the carrier valley, at the carrier peak, or at both. The period register and the carrier type are taken only at the start of each period, so a period in progress always completes with the settings it began with. A trigger strobe, one system clock wide, can mark the valley, the peak, or both. Such a strobe is typically used to start a sampling converter at a known point of the switching cycle.

Top module: `pwm_channel`

## Requirements
- R1: While `rst` is high, `pwm_o` and `trig_o` are 0 and the carrier counter is held at 0. Counting starts on the first clock after release, so the first valley strobe follows release by exactly one carrier period.
- R2: With `ctype_i`=0 (sawtooth), the carrier runs 0,1,…,P−1 and then wraps, giving a period of P ticks. With polarity 0, `pwm_o` is high for C ticks per period for a compare value C in 0..P.
- R3: With `ctype_i`=1 (symmetrical), the carrier runs 0 up to H=floor(P/2) and then back down to 1, giving a period of 2H ticks. With polarity 0, `pwm_o` is high for 2C−1 ticks per period when 1≤C≤H, and for 0 ticks when C=0.
- R4: `pol_i`=1 inverts the output, so the low time per period equals the high time that polarity 0 would give.
- R5: A compare value above the carrier peak saturates and holds the output fully on for the whole period. A compare value of 0 holds it fully off.
- R6: A period value below 20 is loaded as 20.
- R7: The prescaler code n (0..15) on `psc_i` makes the carrier advance once every 2^n clocks. All carrier times scale by 2^n.
- R8: The period value and the carrier type are captured only when the carrier wraps to 0. A change to either in mid-period takes effect from the next period.
- R9: Load mode 0 on `upd_mode_i` (immediate) copies the compare input into the active register on every clock. A change therefore reaches `pwm_o` two clocks later.
- R10: Load mode 1 (valley) loads the compare value only on the tick where the carrier wraps to 0.
- R11: For a symmetrical carrier, load mode 2 loads the compare value at the peak and mode 3 loads it at both peak and valley. For a sawtooth carrier, modes 2 and 3 behave as mode 1.
- R12: `trig_sel_i` selects the strobes on `trig_o`: bit 0 enables the valley strobe and bit 1 enables the peak strobe. A value of 0 gives no strobe. Each strobe is high for one clock, in the clock where the carrier register takes the valley or peak value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads period, type and compare |
| prd_i | input | 16 | Carrier period in counting ticks (floor 20) |
| cmp_i | input | 16 | Compare value |
| ctype_i | input | 1 | Carrier type: 0 sawtooth, 1 symmetrical |
| upd_mode_i | input | 2 | Compare load mode: 0 immediate, 1 valley, 2 peak, 3 both |
| pol_i | input | 1 | Output polarity: 1 inverts |
| psc_i | input | 4 | Prescaler code n, counting clock = clk / 2^n |
| trig_sel_i | input | 2 | Strobe select: bit 0 valley, bit 1 peak |
| pwm_o | output | 1 | Registered PWM output |
| trig_o | output | 1 | Registered one-clock event strobe |

## Verification
The checker relies on the period input being sampled only during reset or at a wrap, so that the period register never holds a value under the floor. It also relies on the carrier counter staying inside the range set by the latched period and type. The stimulus changes the period, type and prescaler only through reset, except in the one deliberate mid-period period change. Compare and mode changes are made at measured offsets from a valley strobe, so the carrier position at each sample point is known. Each steady-state measurement waits for a complete period after the strobe before it counts high clocks.

// File: rtl/pwm_channel_pkg.sv
package pwm_channel_pkg;
  // carrier shape
  typedef enum logic {
    CAR_SAW = 1'b0,
    CAR_TRI = 1'b1
  } carrier_e;

  // compare load point
  typedef enum logic [1:0] {
    LD_NOW    = 2'd0,
    LD_VALLEY = 2'd1,
    LD_PEAK   = 2'd2,
    LD_BOTH   = 2'd3
  } load_e;

  // shortest legal carrier period in counting ticks
  localparam int unsigned MIN_PERIOD = 20;
endpackage

// File: rtl/pwm_channel_prescaler.sv
// Power-of-two tick generator: free-running divider, tick when the low
// code_i bits are all ones.
module pwm_channel_prescaler #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask   = ~({DIV_W{1'b1}} << code_i);
    tick_o = ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel_carrier.sv
// Carrier counter with period/type latched at each wrap to zero.
module pwm_channel_carrier
  import pwm_channel_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [PW-1:0] prd_i,
  input  carrier_e      ctype_i,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] prd_o,
  output carrier_e      ctype_o,
  output logic [PW-1:0] top_o,
  output logic          enter_min_o,
  output logic          enter_max_o
);
  localparam logic [PW-1:0] FLOOR = PW'(MIN_PERIOD);

  logic [PW-1:0] cnt_q, prd_q, cnt_n, half, top, prd_clamped;
  carrier_e      ct_q;
  logic          down_q, down_n, wrap;

  always_comb begin
    prd_clamped = (prd_i < FLOOR) ? FLOOR : prd_i;
    half        = prd_q >> 1;
    top         = (ct_q == CAR_SAW) ? (prd_q - 1'b1) : half;
    cnt_n       = cnt_q;
    down_n      = down_q;
    wrap        = 1'b0;
    if (ct_q == CAR_SAW) begin
      if (cnt_q >= top) begin
        cnt_n = '0;
        wrap  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (!down_q) begin
      // rising half of the triangle
      if (cnt_q >= half) begin
        cnt_n  = cnt_q - 1'b1;
        down_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else begin
      // falling half, the step into zero ends the period
      if (cnt_q <= 1) begin
        cnt_n  = '0;
        down_n = 1'b0;
        wrap   = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      prd_q  <= prd_clamped;
      ct_q   <= ctype_i;
    end else if (tick_i) begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      if (wrap) begin
        prd_q  <= prd_clamped;
        ct_q   <= ctype_i;
        down_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cnt_o       = cnt_q;
    prd_o       = prd_q;
    ctype_o     = ct_q;
    top_o       = top;
    enter_min_o = tick_i && wrap;
    if (ct_q == CAR_SAW) enter_max_o = tick_i && !wrap && (cnt_n == top);
    else                 enter_max_o = tick_i && !down_q && (cnt_n == half);
  end
endmodule

// File: rtl/pwm_channel_cmp_load.sv
// Active compare register with selectable load point and saturation.
module pwm_channel_cmp_load
  import pwm_channel_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] cmp_i,
  input  load_e         mode_i,
  input  carrier_e      ctype_i,
  input  logic          enter_min_i,
  input  logic          enter_max_i,
  input  logic [PW-1:0] top_i,
  output logic [PW-1:0] cmp_o
);
  logic [PW-1:0] act_q, lim;
  logic          load;

  always_comb begin
    unique case (mode_i)
      LD_NOW:    load = 1'b1;
      LD_VALLEY: load = enter_min_i;
      LD_PEAK:   load = (ctype_i == CAR_SAW) ? enter_min_i : enter_max_i;
      LD_BOTH:   load = (ctype_i == CAR_SAW) ? enter_min_i
                                             : (enter_min_i || enter_max_i);
      default:   load = 1'b0;
    endcase
    // one above the peak means always on
    lim   = top_i + 1'b1;
    cmp_o = (act_q > lim) ? lim : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst)       act_q <= cmp_i;
    else if (load) act_q <= cmp_i;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_channel_pkg::*;
#(
  parameter int PW     = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     prd_i,
  input  logic [PW-1:0]     cmp_i,
  input  logic              ctype_i,
  input  logic [1:0]        upd_mode_i,
  input  logic              pol_i,
  input  logic [CODE_W-1:0] psc_i,
  input  logic [1:0]        trig_sel_i,
  output logic              pwm_o,
  output logic              trig_o
);
  logic          tick;
  logic [PW-1:0] cnt, prd_q, top, eff_cmp;
  carrier_e      ct_q;
  logic          enter_min, enter_max;

  pwm_channel_prescaler #(.CODE_W(CODE_W)) psc_u (
    .clk    (clk),
    .rst    (rst),
    .code_i (psc_i),
    .tick_o (tick)
  );

  pwm_channel_carrier #(.PW(PW)) car_u (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .prd_i       (prd_i),
    .ctype_i     (carrier_e'(ctype_i)),
    .cnt_o       (cnt),
    .prd_o       (prd_q),
    .ctype_o     (ct_q),
    .top_o       (top),
    .enter_min_o (enter_min),
    .enter_max_o (enter_max)
  );

  pwm_channel_cmp_load #(.PW(PW)) cmp_u (
    .clk         (clk),
    .rst         (rst),
    .cmp_i       (cmp_i),
    .mode_i      (load_e'(upd_mode_i)),
    .ctype_i     (ct_q),
    .enter_min_i (enter_min),
    .enter_max_i (enter_max),
    .top_i       (top),
    .cmp_o       (eff_cmp)
  );

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o  <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      pwm_o  <= (eff_cmp > cnt) ^ pol_i;
      trig_o <= (enter_min && trig_sel_i[0]) || (enter_max && trig_sel_i[1]);
    end
  end
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [PW-1:0] cnt,
  input logic [PW-1:0] prd_q,
  input logic          ct_q,
  input logic          trig_o,
  input logic [1:0]    trig_sel_i
);
  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R6
  prd_floor_chk: assert property (@(posedge clk) disable iff (rst)
    prd_q >= PW'(20));

  // R8
  prd_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prd_q) |-> (cnt == '0));

  // R2
  saw_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ct_q == 1'b0) |-> (cnt < prd_q));

  // R3
  tri_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ct_q == 1'b1) |-> (cnt <= (prd_q >> 1)));

  // R12
  trig_sel_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> ($past(trig_sel_i) != 2'd0));
endmodule

bind pwm_channel pwm_channel_chk #(.PW(PW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .cnt        (cnt),
  .prd_q      (prd_q),
  .ct_q       (ct_q),
  .trig_o     (trig_o),
  .trig_sel_i (trig_sel_i)
);

// File: tb/pwm_channel_tb_top.sv
`timescale 1ns/1ps
module pwm_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] prd_i = 16'd40;
  logic [15:0] cmp_i = 16'd10;
  logic        ctype_i = 1'b0;
  logic [1:0]  upd_mode_i = 2'd1;
  logic        pol_i = 1'b0;
  logic [3:0]  psc_i = 4'd0;
  logic [1:0]  trig_sel_i = 2'd1;
  logic        pwm_o, trig_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pwm_channel dut_i (
    .clk(clk), .rst(rst), .prd_i(prd_i), .cmp_i(cmp_i), .ctype_i(ctype_i),
    .upd_mode_i(upd_mode_i), .pol_i(pol_i), .psc_i(psc_i),
    .trig_sel_i(trig_sel_i), .pwm_o(pwm_o), .trig_o(trig_o)
  );

  // {pol, type, psc, prd, cmp, high clocks, period clocks}
  localparam int NV = 13;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0, 16'd40,  16'd10,  16'd10, 16'd40},
    {1'b0, 1'b0, 4'd0, 16'd40,  16'd0,   16'd0,  16'd40},
    {1'b0, 1'b0, 4'd0, 16'd40,  16'd40,  16'd40, 16'd40},
    {1'b0, 1'b0, 4'd0, 16'd40,  16'd500, 16'd40, 16'd40},
    {1'b1, 1'b0, 4'd0, 16'd40,  16'd10,  16'd30, 16'd40},
    {1'b0, 1'b0, 4'd0, 16'd5,   16'd3,   16'd3,  16'd20},
    {1'b0, 1'b0, 4'd2, 16'd20,  16'd5,   16'd20, 16'd80},
    {1'b0, 1'b1, 4'd0, 16'd40,  16'd10,  16'd19, 16'd40},
    {1'b0, 1'b1, 4'd0, 16'd41,  16'd20,  16'd39, 16'd40},
    {1'b0, 1'b1, 4'd0, 16'd40,  16'd25,  16'd40, 16'd40},
    {1'b1, 1'b1, 4'd0, 16'd40,  16'd10,  16'd21, 16'd40},
    {1'b0, 1'b1, 4'd1, 16'd40,  16'd0,   16'd0,  16'd80},
    {1'b0, 1'b1, 4'd0, 16'd6,   16'd3,   16'd5,  16'd20}
  };
  string vtag [NV] = '{"R2", "R5", "R2", "R5", "R4", "R6", "R7",
                       "R3", "R3", "R5", "R4", "R7", "R6"};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!trig_o && waited < 2000);
  endtask

  task automatic measure(output int gap, output int hi);
    gap = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      gap++;
      hi += int'(pwm_o);
    end while (!trig_o && gap < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, h;
    // R1: reset state and start of counting
    pol_i = 1'b1;
    rst   = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_o), 0);
    chk("R1 trig in reset", int'(trig_o), 0);
    pol_i = 1'b0;
    rst   = 1'b0;
    wait_pulse(g);
    chk("R1 first valley after release", g, 40);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pol_i   = VEC[i][69];
      ctype_i = VEC[i][68];
      psc_i   = VEC[i][67:64];
      prd_i   = VEC[i][63:48];
      cmp_i   = VEC[i][47:32];
      upd_mode_i = 2'd1;
      trig_sel_i = 2'd1;
      do_reset();
      wait_pulse(g);
      measure(g, h);
      chk({vtag[i], " period"}, g, int'(VEC[i][15:0]));
      chk({vtag[i], " high"}, h, int'(VEC[i][31:16]));
    end

    // R8: mid-period period change
    ctype_i = 1'b0; psc_i = 4'd0; pol_i = 1'b0; prd_i = 16'd40; cmp_i = 16'd10;
    do_reset();
    wait_pulse(g);
    repeat (10) @(negedge clk);
    prd_i = 16'd60;
    measure(g, h);
    chk("R8 current period kept", g, 30);
    measure(g, h);
    chk("R8 new period", g, 60);

    // R9 / R10 / R11 (saw): change compare at carrier 20
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      ctype_i = 1'b0; prd_i = 16'd40; cmp_i = 16'd10; upd_mode_i = 2'(m);
      do_reset();
      wait_pulse(g);
      wait_pulse(g);
      repeat (20) @(negedge clk);
      cmp_i = 16'd30;
      repeat (3) @(negedge clk);
      if (m == 0) chk("R9 immediate load", int'(pwm_o), 1);
      else if (m == 1) chk("R10 valley load holds", int'(pwm_o), 0);
      else chk("R11 saw peak mode as valley", int'(pwm_o), 0);
      wait_pulse(g);
      measure(g, h);
      chk("R10 new compare next period", h, 30);
    end

    // R10 / R11 (triangle): change at carrier 5 rising
    for (int m = 1; m < 4; m++) begin
      @(negedge clk);
      ctype_i = 1'b1; prd_i = 16'd40; cmp_i = 16'd4; upd_mode_i = 2'(m);
      do_reset();
      wait_pulse(g);
      wait_pulse(g);
      repeat (5) @(negedge clk);
      cmp_i = 16'd18;
      repeat (10) @(negedge clk);
      chk("R11 rising half keeps old", int'(pwm_o), 0);
      repeat (10) @(negedge clk);
      if (m == 1) chk("R10 falling half keeps old", int'(pwm_o), 0);
      else        chk("R11 peak load on falling half", int'(pwm_o), 1);
      wait_pulse(g);
      measure(g, h);
      chk("R11 full period new compare", h, 35);
    end

    // R12: strobe selection
    @(negedge clk);
    ctype_i = 1'b1; prd_i = 16'd40; cmp_i = 16'd10; upd_mode_i = 2'd1;
    trig_sel_i = 2'd3;
    do_reset();
    wait_pulse(g);
    measure(g, h);
    chk("R12 both strobes spacing", g, 20);
    @(negedge clk);
    ctype_i = 1'b0; trig_sel_i = 2'd2;
    do_reset();
    wait_pulse(g);
    chk("R12 first peak strobe", g, 39);
    measure(g, h);
    chk("R12 peak strobe spacing", g, 40);
    trig_sel_i = 2'd0;
    begin
      int cnt_p = 0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        cnt_p += int'(trig_o);
      end
      chk("R12 no strobe when disabled", cnt_p, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule